// File: doc/BRIEF.md
# Interrupt Request and Wake Aggregator

This block gathers the interrupt sources of a small 8-bit controller into a single request line toward the CPU and a separate wake line for the sleep logic. Three core sources are handled locally, each with a sticky flag and its own enable. The first is an edge on an external pin, with a selectable polarity, taken through a synchronizer. The second is a one-cycle strobe that marks an 8-bit timer wrapping from FFh to 00h. The third is a mismatch between a six-pin port and a snapshot of it, with a mask for each pin.

Peripheral flag and enable pairs arrive from outside and reach the request only through a shared peripheral gate. A global enable decides whether the CPU is sent to the interrupt vector. The wake line ignores the global enable, so an enabled and flagged source always brings the device out of sleep. Software loads a six-bit control word, loads the pin mask, pulses clear strobes for each flag, and pulses a port-read strobe that refreshes the snapshot.

Top module: `intagg_top`

## Requirements
- R1: A synchronous reset (rstN low at a clock edge) clears every flag and enable and sets the edge polarity to rising, which gives a control word of 6'b100000. It also loads the port snapshot from the pins, so a steady nonzero port raises no change flag after reset.
- R2: The control word has these bits: bit0 global, bit1 peripheral gate, bit2 external enable, bit3 timer enable, bit4 port-change enable, bit5 edge polarity (1 rising, 0 falling). The external flag sets only on the selected edge of extPin. It is visible on irqReq at the third rising clock edge after the pin changes: two synchronizer stages, then the flag register. The opposite edge has no effect.
- R3: Flags are sticky. A flag drops only one cycle after its flagClr bit (bit0 external, bit1 timer, bit2 port change). When a set condition and a clear arrive in the same cycle, the set wins.
- R4: A pulse on tmrWrap sets the timer flag at the next clock edge.
- R5: The port-change flag sets at the next edge when any pin whose mask bit is 1 differs from the snapshot. It keeps being set while that mismatch remains. Pins whose mask bit is 0 are ignored.
- R6: A cycle with portRead high copies the pins into the snapshot, and a change present in that same cycle does not set the port-change flag.
- R7: The peripheral term is high when the peripheral gate bit is 1 and at least one index has both perFlags and perEnables at 1. It reaches the outputs combinationally.
- R8: irqReq is the global bit ANDed with the OR of (flag AND enable) over the core sources and the peripheral term. vecAddr equals VEC_ADDR (0004h) while irqReq is high and zero otherwise.
- R9: wakeUp is sleeping ANDed with the same OR, whatever the global bit.
- R10: A flag sets even while its source enable is 0. Setting the enable afterwards raises the request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| extPin | input | 1 | Asynchronous external interrupt pin |
| tmrWrap | input | 1 | One-cycle strobe on timer wrap FFh to 00h |
| portPins | input | NPINS | Port pins watched for change |
| portRead | input | 1 | Port read strobe, refreshes the snapshot |
| perFlags | input | NPER | Peripheral interrupt flags |
| perEnables | input | NPER | Peripheral interrupt enables |
| ctlWr | input | 1 | Load strobe for the control word |
| ctlData | input | 6 | Control word value |
| maskWr | input | 1 | Load strobe for the pin mask |
| maskData | input | NPINS | Pin mask value |
| flagClr | input | 3 | Clear strobes for the external, timer and port-change flags |
| sleeping | input | 1 | Device is asleep |
| irqReq | output | 1 | Interrupt request to the CPU |
| wakeUp | output | 1 | Wake request to the sleep logic |
| vecAddr | output | VEC_W | Interrupt vector while requesting, else zero |

## Verification
Each result has its own latency, and every check is sampled at a falling edge after exactly that many rising edges from its stimulus. The peripheral, sleep and vector results are combinational, so the bench samples them one time step after the input change. Timer, port and clear effects appear after one rising edge, and a control-word load also counts one edge. An external edge is first checked as still absent after two rising edges and then as present after the third, which holds the synchronizer depth exactly.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int SRC_N   = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_CHG = 2;

  localparam int CTL_W      = 6;
  localparam int CTL_GLOBAL = 0;
  localparam int CTL_PERIPH = 1;
  localparam int CTL_EXT    = 2;
  localparam int CTL_TMR    = 3;
  localparam int CTL_CHG    = 4;
  localparam int CTL_EDGE   = 5;
  localparam logic [CTL_W-1:0] CTL_RESET = 6'b100000;

  typedef struct packed {
    logic [SRC_N-1:0] setSrc;
    logic [SRC_N-1:0] clrSrc;
    logic             ctlLoad;
    logic             maskLoad;
    logic             snapTake;
  } strobe_t;
endpackage

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
  import intagg_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic             edgeRise,
  input  logic             tmrWrap,
  input  logic             portRead,
  input  logic             chgSeen,
  input  logic [SRC_N-1:0] flagClr,
  input  logic             ctlWr,
  input  logic             maskWr,
  output strobe_t          strb
);
  localparam int WARM  = SYNC_N + 1;
  localparam int CNT_W = $clog2(WARM + 1);

  logic [SYNC_N-1:0] syncChain;
  logic              prevSample;
  logic [CNT_W-1:0]  warmCnt;
  logic              syncOut;
  logic              warmDone;
  logic              edgeHit;

  // synchronizer chain, stage 0 samples the raw pin
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= extPin;
    end
  end

  generate
    for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= 1'b0;
      warmCnt    <= '0;
    end else begin
      prevSample <= syncOut;
      if (!warmDone) warmCnt <= warmCnt + 1'b1;
    end
  end

  // edges are ignored until the chain holds real pin samples
  assign warmDone = (warmCnt == CNT_W'(WARM));
  assign edgeHit  = warmDone &&
                    (edgeRise ? (syncOut && !prevSample) : (!syncOut && prevSample));

  always_comb begin
    strb                  = '0;
    strb.setSrc[SRC_EXT]  = edgeHit;
    strb.setSrc[SRC_TMR]  = tmrWrap;
    // a change coinciding with a snapshot is lost
    strb.setSrc[SRC_CHG]  = chgSeen && !portRead;
    strb.clrSrc           = flagClr;
    strb.ctlLoad          = ctlWr;
    strb.maskLoad         = maskWr;
    strb.snapTake         = portRead;
  end
endmodule

// File: rtl/intagg_dp.sv
module intagg_dp
  import intagg_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int NPER  = 4,
  parameter int VEC_W = 13,
  parameter logic [VEC_W-1:0] VEC_ADDR = 'h4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CTL_W-1:0] ctlData,
  input  logic [NPINS-1:0] maskData,
  input  logic [NPINS-1:0] portPins,
  input  logic [NPER-1:0]  perFlags,
  input  logic [NPER-1:0]  perEnables,
  input  logic             sleeping,
  output logic             edgeRise,
  output logic             chgSeen,
  output logic [SRC_N-1:0] srcFlags,
  output logic             irqReq,
  output logic             wakeUp,
  output logic [VEC_W-1:0] vecAddr
);
  logic [CTL_W-1:0] ctlReg;
  logic [NPINS-1:0] pinMask;
  logic [NPINS-1:0] snapReg;
  logic [SRC_N-1:0] flagReg;
  logic [SRC_N-1:0] srcEn;
  logic             coreHit;
  logic             perHit;
  logic             anyHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= CTL_RESET;
      pinMask <= '0;
      snapReg <= portPins;
    end else begin
      if (strb.ctlLoad)  ctlReg  <= ctlData;
      if (strb.maskLoad) pinMask <= maskData;
      if (strb.snapTake) snapReg <= portPins;
    end
  end

  // sticky flags, a set beats a clear in the same cycle
  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN)                flagReg[i] <= 1'b0;
        else if (strb.setSrc[i])  flagReg[i] <= 1'b1;
        else if (strb.clrSrc[i])  flagReg[i] <= 1'b0;
      end
    end
  endgenerate

  assign chgSeen  = |((portPins ^ snapReg) & pinMask);
  assign edgeRise = ctlReg[CTL_EDGE];
  assign srcFlags = flagReg;

  always_comb begin
    srcEn          = '0;
    srcEn[SRC_EXT] = ctlReg[CTL_EXT];
    srcEn[SRC_TMR] = ctlReg[CTL_TMR];
    srcEn[SRC_CHG] = ctlReg[CTL_CHG];
  end

  assign coreHit = |(flagReg & srcEn);
  assign perHit  = ctlReg[CTL_PERIPH] && (|(perFlags & perEnables));
  assign anyHit  = coreHit || perHit;
  assign irqReq  = ctlReg[CTL_GLOBAL] && anyHit;
  assign wakeUp  = sleeping && anyHit;
  assign vecAddr = irqReq ? VEC_ADDR : '0;
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int NPINS  = 6,
  parameter int NPER   = 4,
  parameter int SYNC_N = 2,
  parameter int VEC_W  = 13,
  parameter logic [VEC_W-1:0] VEC_ADDR = 'h4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic             tmrWrap,
  input  logic [NPINS-1:0] portPins,
  input  logic             portRead,
  input  logic [NPER-1:0]  perFlags,
  input  logic [NPER-1:0]  perEnables,
  input  logic             ctlWr,
  input  logic [5:0]       ctlData,
  input  logic             maskWr,
  input  logic [NPINS-1:0] maskData,
  input  logic [2:0]       flagClr,
  input  logic             sleeping,
  output logic             irqReq,
  output logic             wakeUp,
  output logic [VEC_W-1:0] vecAddr
);
  strobe_t          strb;
  logic             edgeRise;
  logic             chgSeen;
  logic [SRC_N-1:0] srcFlags;

  intagg_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .edgeRise(edgeRise),
    .tmrWrap(tmrWrap), .portRead(portRead), .chgSeen(chgSeen),
    .flagClr(flagClr), .ctlWr(ctlWr), .maskWr(maskWr), .strb(strb)
  );

  intagg_dp #(.NPINS(NPINS), .NPER(NPER), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctlData(ctlData), .maskData(maskData),
    .portPins(portPins), .perFlags(perFlags), .perEnables(perEnables),
    .sleeping(sleeping), .edgeRise(edgeRise), .chgSeen(chgSeen),
    .srcFlags(srcFlags), .irqReq(irqReq), .wakeUp(wakeUp), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk
  import intagg_pkg::*;
#(
  parameter int VEC_W = 13,
  parameter logic [VEC_W-1:0] VEC_ADDR = 'h4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sleeping,
  input logic             irqReq,
  input logic             wakeUp,
  input logic [VEC_W-1:0] vecAddr,
  input logic [SRC_N-1:0] srcFlags,
  input strobe_t          strb
);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcFlags & ~strb.clrSrc)) |=> ((($past(srcFlags) & ~$past(strb.clrSrc)) & ~srcFlags) == '0));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.setSrc) |=> ((($past(strb.setSrc)) & ~srcFlags) == '0));

  // R8
  vec_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecAddr == VEC_ADDR));

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (vecAddr == '0));

  // R9
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> sleeping);

  // R9
  wake_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && irqReq) |-> wakeUp);
endmodule

bind intagg_top intagg_chk #(.VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .sleeping(sleeping), .irqReq(irqReq),
  .wakeUp(wakeUp), .vecAddr(vecAddr), .srcFlags(srcFlags), .strb(strb)
);

// File: tb/intagg_top_tb.sv
module intagg_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 6;
  localparam int NPER  = 4;
  localparam int VEC_W = 13;
  localparam logic [VEC_W-1:0] VEC = 13'h0004;

  logic             clk = 1'b0;
  logic             rstN;
  logic             extPin;
  logic             tmrWrap;
  logic [NPINS-1:0] portPins;
  logic             portRead;
  logic [NPER-1:0]  perFlags;
  logic [NPER-1:0]  perEnables;
  logic             ctlWr;
  logic [5:0]       ctlData;
  logic             maskWr;
  logic [NPINS-1:0] maskData;
  logic [2:0]       flagClr;
  logic             sleeping;
  logic             irqReq;
  logic             wakeUp;
  logic [VEC_W-1:0] vecAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intagg_top u_dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .tmrWrap(tmrWrap),
    .portPins(portPins), .portRead(portRead), .perFlags(perFlags),
    .perEnables(perEnables), .ctlWr(ctlWr), .ctlData(ctlData),
    .maskWr(maskWr), .maskData(maskData), .flagClr(flagClr),
    .sleeping(sleeping), .irqReq(irqReq), .wakeUp(wakeUp), .vecAddr(vecAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic writeCtl(input logic [5:0] d);
    ctlWr = 1'b1; ctlData = d;
    step();
    ctlWr = 1'b0;
  endtask

  task automatic writeMask(input logic [NPINS-1:0] d);
    maskWr = 1'b1; maskData = d;
    step();
    maskWr = 1'b0;
  endtask

  task automatic pulseClr(input logic [2:0] c);
    flagClr = c;
    step();
    flagClr = 3'b000;
  endtask

  task automatic doReset(input logic [NPINS-1:0] pins);
    rstN = 1'b0; extPin = 1'b0; tmrWrap = 1'b0; portPins = pins;
    portRead = 1'b0; perFlags = '0; perEnables = '0; ctlWr = 1'b0;
    ctlData = '0; maskWr = 1'b0; maskData = '0; flagClr = '0; sleeping = 1'b0;
    steps(3);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(6'h2A);
    sleeping = 1'b1;
    #1;
    check("R1 irq after reset", irqReq, 0);
    check("R1 wake after reset", wakeUp, 0);
    check("R1 vec after reset", vecAddr, 0);
    sleeping = 1'b0;
    writeMask(6'h3F);
    writeCtl(6'b110001);
    step();
    check("R1 snapshot loaded at reset", irqReq, 0);

    // port change, masked pins
    writeMask(6'h01);
    portPins = 6'h22; step();
    check("R5 masked pin ignored", irqReq, 0);
    portPins = 6'h23; step();
    check("R5 unmasked pin sets flag", irqReq, 1);
    pulseClr(3'b100);
    check("R5 persistent mismatch re-sets", irqReq, 1);
    portRead = 1'b1; step(); portRead = 1'b0;
    check("R3 flag stays after snapshot", irqReq, 1);
    pulseClr(3'b100);
    check("R3 clear drops port flag", irqReq, 0);
    portPins = 6'h22; portRead = 1'b1; step(); portRead = 1'b0;
    step();
    check("R6 change during read lost", irqReq, 0);
    portPins = 6'h23; step();
    check("R6 later change detected", irqReq, 1);
    portRead = 1'b1; flagClr = 3'b100; step(); portRead = 1'b0; flagClr = 3'b000;
    check("R6 read with clear", irqReq, 0);

    // external edge
    writeCtl(6'b100101);
    extPin = 1'b1; steps(2);
    check("R2 rising not yet visible", irqReq, 0);
    step();
    check("R2 rising visible third edge", irqReq, 1);
    pulseClr(3'b001);
    check("R3 clear external flag", irqReq, 0);
    extPin = 1'b0; steps(4);
    check("R2 falling ignored in rising mode", irqReq, 0);
    writeCtl(6'b000101);
    extPin = 1'b1; steps(4);
    check("R2 rising ignored in falling mode", irqReq, 0);
    extPin = 1'b0; steps(2);
    check("R2 falling not yet visible", irqReq, 0);
    step();
    check("R2 falling visible third edge", irqReq, 1);
    extPin = 1'b1; steps(5);
    check("R3 external flag sticky", irqReq, 1);
    pulseClr(3'b001);
    check("R3 external cleared", irqReq, 0);

    // timer
    writeCtl(6'b000001);
    tmrWrap = 1'b1; step(); tmrWrap = 1'b0;
    check("R10 disabled source no request", irqReq, 0);
    writeCtl(6'b001001);
    check("R10 enable after flag", irqReq, 1);
    check("R8 vector while requesting", vecAddr, 32'(VEC));
    pulseClr(3'b010);
    check("R4 timer flag cleared", irqReq, 0);
    tmrWrap = 1'b1; step(); tmrWrap = 1'b0;
    check("R4 timer wrap sets flag", irqReq, 1);
    tmrWrap = 1'b1; flagClr = 3'b010; step(); tmrWrap = 1'b0; flagClr = 3'b000;
    check("R3 set wins over clear", irqReq, 1);
    pulseClr(3'b010);

    // peripheral
    writeCtl(6'b000011);
    perFlags = 4'b0100; perEnables = 4'b0010; #1;
    check("R7 unmatched pair", irqReq, 0);
    perEnables = 4'b0110; #1;
    check("R7 matched pair", irqReq, 1);
    writeCtl(6'b000001);
    check("R7 gate off", irqReq, 0);
    perFlags = '0; perEnables = '0;

    // wake without global enable
    writeCtl(6'b001000);
    tmrWrap = 1'b1; step(); tmrWrap = 1'b0;
    check("R9 awake no wake", wakeUp, 0);
    sleeping = 1'b1; #1;
    check("R9 wake without global", wakeUp, 1);
    check("R8 no request without global", irqReq, 0);
    check("R8 idle vector", vecAddr, 0);
    sleeping = 1'b0;

    // sweep: flag subsets x control words x peripheral pair x sleep
    for (int m = 0; m < 8; m++) begin
      doReset(6'h00);
      writeMask(6'h3F);
      writeCtl(6'b100000);
      if (m[0]) begin extPin = 1'b1; steps(3); end
      if (m[1]) begin tmrWrap = 1'b1; step(); tmrWrap = 1'b0; end
      if (m[2]) begin
        portPins = 6'h01; step();
        portRead = 1'b1; step(); portRead = 1'b0;
      end
      for (int c = 0; c < 32; c++) begin
        writeCtl({1'b1, 5'(c)});
        for (int pp = 0; pp < 4; pp++) begin
          for (int s = 0; s < 2; s++) begin
            logic core, per, any, expIrq, expWake;
            perFlags = {3'b000, pp[0]};
            perEnables = {3'b000, pp[1]};
            sleeping = s[0];
            #1;
            core = (m[0] & c[2]) | (m[1] & c[3]) | (m[2] & c[4]);
            per = c[1] & pp[0] & pp[1];
            any = core | per;
            expIrq = c[0] & any;
            expWake = s[0] & any;
            check("R8 sweep request", irqReq, expIrq);
            check("R9 sweep wake", wakeUp, expWake);
            check("R8 sweep vector", vecAddr, expIrq ? 32'(VEC) : 32'd0);
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule